// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block pairs a bus initiator with a single responding word store over an interlocked request/acknowledge handshake. The two sides share one clock, but neither trusts the other's strobe directly: each incoming strobe passes through a two-stage synchroniser before it can move a state machine. This lets the link be timed in whole cycles while keeping the ordering of an unclocked four-phase exchange.

A user hands the initiator one command at a time (read or write, address, write data). The initiator puts the address, the direction and any write data on the lines. It holds them for a programmable decode interval and then raises the request. The responder stores the word or drives the stored word and raises the acknowledge. The initiator then drops the request, capturing read data as it does. The responder drops the acknowledge once it sees the request low. Only after the initiator sees the acknowledge low does it report completion and take the next command.

Initiator states: `M_IDLE` (ready; a command moves it to `M_SETUP`), `M_SETUP` (lines driven, decode count running; the last count moves it to `M_REQ`), `M_REQ` (request high; a synchronised acknowledge moves it to `M_REL`), `M_REL` (request low; a synchronised acknowledge low moves it back to `M_IDLE` with a completion pulse). Responder states: `S_IDLE` (a synchronised request moves it to `S_ACK`, storing write data on the way), `S_ACK` (acknowledge high; a synchronised request low returns it to `S_IDLE`).

Top module: `hs4_link`

## Requirements
- R1: After reset the request, acknowledge, completion pulse and both data-line drive enables are low, `cmd_ready` is high and every stored word reads as zero.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The request rises exactly DECODE_CYC cycles after that edge, with address, direction and write data already on the lines.
- R3: Address and direction on the lines do not change while the request or the acknowledge is high.
- R4: The acknowledge rises only while the responder's synchronised request is high, exactly 3 cycles after the request rises.
- R5: On a write the responder stores the data-line word at the addressed location when it raises the acknowledge, and a later read of that address returns it.
- R6: On a read the responder drives the stored word on the data lines while the acknowledge is high, and the initiator returns that word on `rsp_rdata` with the completion pulse.
- R7: The request falls only after the initiator's synchronised acknowledge is high, exactly 3 cycles after the acknowledge rises.
- R8: The acknowledge falls only after the responder's synchronised request is low, exactly 3 cycles after the request falls.
- R9: `rsp_valid` is a one-cycle pulse DECODE_CYC+12 cycles after the taking edge, and `cmd_ready` is low from the taking edge until the pulse. A `cmd_valid` presented while `cmd_ready` is low has no effect on the lines.
- R10: At most one side drives the data lines. The initiator drives them only for writes, and the responder drives them only while the acknowledge is high on a read. Undriven lines read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | Initiator idle, command can be taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word captured at acknowledge |
| bus_req | output | 1 | Request strobe on the link |
| bus_ack | output | 1 | Acknowledge strobe on the link |
| bus_addr | output | AW | Address lines |
| bus_write | output | 1 | Direction line |
| bus_data | output | DW | Resolved shared data lines |
| mst_drive | output | 1 | Initiator drives the data lines |
| slv_drive | output | 1 | Responder drives the data lines |

## Verification
The bench builds two copies with 3-bit addresses and 8-bit words. One uses a decode interval of 3 and the other the minimum of 1, so both a multi-cycle count and the single-cycle edge of the decode counter are exercised. With eight locations, every address is written and read back on both copies. Each transaction's four strobe edges and its completion are timed against the arithmetic offsets of R2, R4, R7, R8 and R9. A stray command is held on the inputs during every busy period.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SETUP = 2'd1,
        M_REQ   = 2'd2,
        M_REL   = 2'd3
    } mst_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_e;
endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs4_master.sv
module hs4_master
    import hs4_pkg::*;
#(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int DECODE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          ack_s,
    input  logic [DW-1:0] bus_rdata,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          write_o,
    output logic [DW-1:0] wdata_o,
    output logic          drive_o
);
    localparam int CW = $clog2(DECODE_CYC + 1);

    mst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          write_q;
    logic [DW-1:0] wdata_q;
    logic          take;

    assign take = cmd_valid && (state_q == M_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:  if (cmd_valid)            state_d = M_SETUP;
            M_SETUP: if (cnt_q == CW'(1))      state_d = M_REQ;
            M_REQ:   if (ack_s)                state_d = M_REL;
            M_REL:   if (!ack_s)               state_d = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            addr_q    <= '0;
            write_q   <= 1'b0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == M_REL) && !ack_s;
            if (take) begin
                cnt_q   <= CW'(DECODE_CYC);
                addr_q  <= cmd_addr;
                write_q <= cmd_write;
                wdata_q <= cmd_wdata;
            end else if (state_q == M_SETUP) begin
                cnt_q <= cnt_q - CW'(1);
            end
            if ((state_q == M_REQ) && ack_s && !write_q)
                rsp_rdata <= bus_rdata;
        end
    end

    assign cmd_ready = (state_q == M_IDLE);
    assign req_o     = (state_q == M_REQ);
    assign addr_o    = addr_q;
    assign write_o   = write_q;
    assign wdata_o   = wdata_q;
    assign drive_o   = write_q && ((state_q == M_SETUP) || (state_q == M_REQ));

    // R3: lines frozen while strobes are in flight
    a_r3_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_REQ || state_q == M_REL) |=> $stable(addr_q) && $stable(write_q));

    // R7: request drops only after the synchronised acknowledge
    a_r7_req_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> ack_s);

    // R9: completion is a single-cycle pulse
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s,
    input  logic [AW-1:0] addr_i,
    input  logic          write_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ack_o,
    output logic [DW-1:0] rdata_o,
    output logic          drive_o
);
    localparam int DEPTH = 1 << AW;

    slv_state_e    state_q, state_d;
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_s)  state_d = S_ACK;
            S_ACK:  if (!req_s) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if ((state_q == S_IDLE) && req_s && write_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign ack_o   = (state_q == S_ACK);
    assign rdata_o = mem_q[addr_i];
    assign drive_o = (state_q == S_ACK) && !write_i;

    // R4: acknowledge rises only on a seen request
    a_r4_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> req_s);

    // R8: acknowledge falls only after request seen low
    a_r8_ack_after_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !req_s);
endmodule

// File: rtl/hs4_link.sv
module hs4_link #(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int DECODE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_req,
    output logic          bus_ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_data,
    output logic          mst_drive,
    output logic          slv_drive
);
    logic          req_seen, ack_seen;
    logic [DW-1:0] m_wdata, s_rdata;

    hs4_sync #(.STAGES(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_seen)
    );

    hs4_sync #(.STAGES(2)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_seen)
    );

    hs4_master #(.AW(AW), .DW(DW), .DECODE_CYC(DECODE_CYC)) u_mst (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ack_s(ack_seen), .bus_rdata(bus_data),
        .req_o(bus_req), .addr_o(bus_addr), .write_o(bus_write),
        .wdata_o(m_wdata), .drive_o(mst_drive)
    );

    hs4_slave #(.AW(AW), .DW(DW)) u_slv (
        .clk(clk), .rst_n(rst_n),
        .req_s(req_seen), .addr_i(bus_addr), .write_i(bus_write),
        .wdata_i(bus_data), .ack_o(bus_ack), .rdata_o(s_rdata),
        .drive_o(slv_drive)
    );

    always_comb begin
        if (mst_drive)      bus_data = m_wdata;
        else if (slv_drive) bus_data = s_rdata;
        else                bus_data = '0;
    end

    // R10: never two drivers on the data lines
    a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_drive && slv_drive));

    // R2: request never rises into a standing acknowledge
    a_r2_req_rise_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_ack);
endmodule

// File: tb/sim_hs4_link.sv
module sim_hs4_link;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic          cv [NI];
    logic          cw [NI];
    logic [AW-1:0] ca [NI];
    logic [DW-1:0] cd [NI];
    logic          crdy [NI];
    logic          rv [NI];
    logic [DW-1:0] rd [NI];
    logic          rq [NI];
    logic          ak [NI];
    logic [AW-1:0] ba [NI];
    logic          bw [NI];
    logic [DW-1:0] bd [NI];
    logic          md [NI];
    logic          sd [NI];

    hs4_link #(.AW(AW), .DW(DW), .DECODE_CYC(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cv[0]), .cmd_write(cw[0]),
        .cmd_addr(ca[0]), .cmd_wdata(cd[0]), .cmd_ready(crdy[0]),
        .rsp_valid(rv[0]), .rsp_rdata(rd[0]), .bus_req(rq[0]), .bus_ack(ak[0]),
        .bus_addr(ba[0]), .bus_write(bw[0]), .bus_data(bd[0]),
        .mst_drive(md[0]), .slv_drive(sd[0])
    );

    hs4_link #(.AW(AW), .DW(DW), .DECODE_CYC(1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cv[1]), .cmd_write(cw[1]),
        .cmd_addr(ca[1]), .cmd_wdata(cd[1]), .cmd_ready(crdy[1]),
        .rsp_valid(rv[1]), .rsp_rdata(rd[1]), .bus_req(rq[1]), .bus_ack(ak[1]),
        .bus_addr(ba[1]), .bus_write(bw[1]), .bus_data(bd[1]),
        .mst_drive(md[1]), .slv_drive(sd[1])
    );

    int dly [NI] = '{3, 1};

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // per-instance monitor state
    bit            active [NI];
    logic [AW-1:0] x_addr [NI];
    logic          x_wr   [NI];
    logic [DW-1:0] x_data [NI];
    logic          p_rq [NI];
    logic          p_ak [NI];
    int t_rq_up [NI];
    int t_ak_up [NI];
    int t_rq_dn [NI];
    int t_ak_dn [NI];
    int mon_err [NI];

    task automatic chk(input bit ok, input string rq_tag, input int act, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq_tag, act, exp_v);
        end
    endtask

    always @(negedge clk) begin
        for (int k = 0; k < NI; k++) begin
            if (rst_n) begin
                if (rq[k] && !p_rq[k]) t_rq_up[k] = cyc;
                if (!rq[k] && p_rq[k]) t_rq_dn[k] = cyc;
                if (ak[k] && !p_ak[k]) t_ak_up[k] = cyc;
                if (!ak[k] && p_ak[k]) t_ak_dn[k] = cyc;
                // R3: lines held during strobes
                if (active[k] && (rq[k] || ak[k]) &&
                    (ba[k] !== x_addr[k] || bw[k] !== x_wr[k])) mon_err[k]++;
                // R10: one driver, slave only during read acknowledge
                if (md[k] && sd[k]) mon_err[k]++;
                if (sd[k] && !(ak[k] && !bw[k])) mon_err[k]++;
                if (md[k] && !bw[k]) mon_err[k]++;
                if (!md[k] && !sd[k] && bd[k] !== '0) mon_err[k]++;
                // R6: read word on the lines during acknowledge
                if (active[k] && ak[k] && !x_wr[k] && bd[k] !== x_data[k]) mon_err[k]++;
            end
            p_rq[k] = rq[k];
            p_ak[k] = ak[k];
        end
    end

    function automatic logic [DW-1:0] pat(input int k, input int a);
        return DW'((a * 37 + 11 + k * 90) & 8'hFF);
    endfunction

    task automatic txn(input int k, input bit wr, input int a, input logic [DW-1:0] val);
        int acc;
        int t_rv;
        int e0;
        bit seen;
        e0 = mon_err[k];
        x_addr[k] = AW'(a);
        x_wr[k]   = wr;
        x_data[k] = val;
        cv[k] = 1'b1; cw[k] = wr; ca[k] = AW'(a); cd[k] = wr ? val : 8'h00;
        acc = cyc + 1;
        @(negedge clk);
        active[k] = 1'b1;
        chk(crdy[k] == 1'b0, "R9 ready low when busy", int'(crdy[k]), 0);
        // stray command while busy: R9 says it has no effect
        cw[k] = ~wr; ca[k] = ~AW'(a); cd[k] = 8'hA5;
        for (int i = 0; i < 60 && !ak[k]; i++) @(negedge clk);
        cv[k] = 1'b0;
        seen = 1'b0;
        t_rv = 0;
        for (int i = 0; i < 60; i++) begin
            if (rv[k]) begin seen = 1'b1; t_rv = cyc; break; end
            @(negedge clk);
        end
        active[k] = 1'b0;
        chk(seen, "R9 completion seen", int'(seen), 1);
        chk(t_rq_up[k] - acc == dly[k], "R2 request delay", t_rq_up[k] - acc, dly[k]);
        chk(t_ak_up[k] - t_rq_up[k] == 3, "R4 ack rise", t_ak_up[k] - t_rq_up[k], 3);
        chk(t_rq_dn[k] - t_ak_up[k] == 3, "R7 req fall", t_rq_dn[k] - t_ak_up[k], 3);
        chk(t_ak_dn[k] - t_rq_dn[k] == 3, "R8 ack fall", t_ak_dn[k] - t_rq_dn[k], 3);
        chk(t_rv - acc == dly[k] + 12, "R9 completion latency", t_rv - acc, dly[k] + 12);
        if (!wr) chk(rd[k] == val, wr ? "R5" : "R6 read data", int'(rd[k]), int'(val));
        chk(mon_err[k] == e0, "R3 R10 line checks", mon_err[k] - e0, 0);
        @(negedge clk);
        chk(!rv[k] && crdy[k], "R9 pulse ends, ready", int'(rv[k]), 0);
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            cv[k] = 1'b0; cw[k] = 1'b0; ca[k] = '0; cd[k] = '0;
            active[k] = 1'b0; mon_err[k] = 0;
            t_rq_up[k] = 0; t_ak_up[k] = 0; t_rq_dn[k] = 0; t_ak_dn[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk(!rq[k] && !ak[k] && !rv[k] && !md[k] && !sd[k], "R1 strobes low",
                int'(rq[k]) + int'(ak[k]) + int'(rv[k]), 0);
            chk(crdy[k] == 1'b1, "R1 ready", int'(crdy[k]), 1);
            // R1: stored words reset to zero
            txn(k, 1'b0, 5, 8'h00);
        end
        for (int k = 0; k < NI; k++) begin
            // R5: write every location
            for (int a = 0; a < (1 << AW); a++) txn(k, 1'b1, a, pat(k, a));
            // R5 R6: read back every location
            for (int a = 0; a < (1 << AW); a++) txn(k, 1'b0, a, pat(k, a));
            // R5: overwrite then read
            txn(k, 1'b1, 2, 8'h3C);
            txn(k, 1'b0, 2, 8'h3C);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule